// File: doc/BRIEF.md
# DMA Request Descriptor Sequencer

This block takes one already-decoded DMA request descriptor and steps it through a fixed series of stages:
1. an optional pre-synchronisation semaphore wait;
2. an optional memory transfer;
3. the post-synchronisation semaphore operations;
4. an optional doorbell write;
5. an optional response element.

Each stage is a valid/ready request to a neighbouring unit: the transfer engine, the semaphore unit, the doorbell write port or the response sink. The sequencer holds a stage until the neighbour raises ready, which means that stage is complete. Only then does it move to the next enabled stage.

The descriptor is checked when it is accepted. The illegal cases are:
- a reserved transfer type;
- more than one pre-sync semaphore entry;
- a reserved doorbell width;
- a doorbell address that is not aligned to its width.

Any of these skips every stage. The request then completes with a non-zero completion code, and the response is issued whether or not one was asked for. A command flag can also force a one-cycle interrupt pulse when the request completes.

Top module: `dma_req_seq`

## Requirements
- R1: After reset, `desc_ready_o` is 1, and `xfer_valid_o`, `sem_valid_o`, `db_valid_o`, `rsp_valid_o` and `irq_o` are all 0.
- R2: A legal request issues its enabled stages in this fixed order: pre-sync semaphore, transfer, post-sync semaphores, doorbell, response. Disabled stages are skipped. Each stage waits for its ready before the next stage starts, and only one request valid is high at a time.
- R3: Command bits 1:0 select the transfer: 0 means no transfer, 1 means host-to-device (`xfer_dir_o`=1), 2 means device-to-host (`xfer_dir_o`=0). Command bit 3 appears on `xfer_bulk_o` (1 = bulk, 0 = linked list). Source, destination and the 32-bit length are passed through unchanged.
- R4: A semaphore entry with bit 31 set and bit 30 clear is a post-sync operation. Post-sync entries are issued one at a time in ascending index order, with `sem_pre_o`=0 and `sem_idx_o` giving the entry index.
- R5: A semaphore entry with both bit 31 and bit 30 set is the pre-sync condition. It is issued before any other stage, with `sem_pre_o`=1.
- R6: Doorbell attribute bit 7 enables the doorbell write. Attribute bits 1:0 give its width: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit. `db_size_o` carries that code. `db_data_o` carries only the data bits inside the width; the bits above it are 0.
- R7: An enabled doorbell must be aligned to its width: a 32-bit doorbell needs address bits 1:0 = 0, a 16-bit doorbell needs address bit 0 = 0, and an 8-bit doorbell accepts any address. A violation completes with code 4.
- R8: When command bit 4 is set, a legal request ends with a response carrying its request ID and code 0. When bit 4 is clear and the request is legal, no response is issued.
- R9: Error codes are: 1 for transfer type 3; 2 for more than one pre-sync entry; 3 for doorbell width code 3 with the doorbell enabled; 4 for misalignment. The smallest applicable code wins. An erroneous request issues no stage other than its response, and that response is always issued.
- R10: When command bit 7 is set, `irq_o` is high for exactly the first cycle in which `desc_ready_o` is high again after the request completes. Otherwise `irq_o` stays 0.
- R11: The sequence ID has no effect on any stage and appears unchanged on `rsp_seq_id_o`.
- R12: While any request valid is high and its ready is low, that valid and all of its payload outputs stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Sequencer idle, descriptor accepted |
| desc_req_id_i | input | ID_W | Request ID |
| desc_seq_id_i | input | SEQ_W | Sequence ID, carried to the response |
| desc_cmd_i | input | 8 | Command byte |
| desc_src_i | input | ADDR_W | Transfer source address |
| desc_dst_i | input | ADDR_W | Transfer destination address |
| desc_len_i | input | LEN_W | Transfer length in bytes |
| desc_db_addr_i | input | ADDR_W | Doorbell address |
| desc_db_attr_i | input | 8 | Doorbell enable and width |
| desc_db_data_i | input | DB_W | Doorbell data |
| desc_sem_i | input | NSEM*SEM_W | Semaphore entries, entry 0 in the low bits |
| xfer_valid_o | output | 1 | Transfer request |
| xfer_ready_i | input | 1 | Transfer done |
| xfer_dir_o | output | 1 | 1 = host-to-device |
| xfer_bulk_o | output | 1 | 1 = bulk, 0 = linked list |
| xfer_src_o | output | ADDR_W | Source address |
| xfer_dst_o | output | ADDR_W | Destination address |
| xfer_len_o | output | LEN_W | Length |
| sem_valid_o | output | 1 | Semaphore request |
| sem_ready_i | input | 1 | Semaphore condition met or operation done |
| sem_pre_o | output | 1 | 1 = pre-sync wait |
| sem_idx_o | output | IDX_W | Entry index |
| sem_cmd_o | output | SEM_W | Entry contents |
| db_valid_o | output | 1 | Doorbell write request |
| db_ready_i | input | 1 | Doorbell write done |
| db_addr_o | output | ADDR_W | Doorbell address |
| db_size_o | output | 2 | Width code |
| db_data_o | output | DB_W | Width-masked data |
| rsp_valid_o | output | 1 | Response element |
| rsp_ready_i | input | 1 | Response taken |
| rsp_req_id_o | output | ID_W | Request ID |
| rsp_seq_id_o | output | SEQ_W | Sequence ID |
| rsp_code_o | output | 16 | Completion code, 0 = success |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The embedded assertions check several properties on every cycle:
- at most one request valid is high;
- stalled requests keep their payload stable;
- post-sync indices only increase within a request;
- any doorbell that is issued is aligned and has its upper data bits cleared;
- an error response follows directly from the acceptance cycle.

The exact sequence of stages for a given descriptor can only be shown by the bench's scenarios. The same holds for the priority among several errors, the doorbell case where a reserved width is harmless because the doorbell is disabled, and the timing of the interrupt pulse. The bench covers these with random and directed descriptors against a reference sequence that it computes itself.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int CMD_BULK_BIT = 3;
  localparam int CMD_RSP_BIT  = 4;
  localparam int CMD_IRQ_BIT  = 7;
  localparam int DB_EN_BIT    = 7;
  localparam int CODE_W       = 16;

  typedef enum logic [1:0] {
    XT_NONE     = 2'd0,
    XT_TO_DEV   = 2'd1,
    XT_FROM_DEV = 2'd2,
    XT_ILLEGAL  = 2'd3
  } xfer_type_e;

  typedef enum logic [1:0] {
    DBW_32   = 2'd0,
    DBW_16   = 2'd1,
    DBW_8    = 2'd2,
    DBW_RSVD = 2'd3
  } db_width_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_XFER = 3'd2,
    ST_POST = 3'd3,
    ST_DB   = 3'd4,
    ST_RSP  = 3'd5
  } seq_state_e;

  typedef logic [CODE_W-1:0] cpl_code_t;

  localparam cpl_code_t CPL_OK        = 16'd0;
  localparam cpl_code_t CPL_BAD_TYPE  = 16'd1;
  localparam cpl_code_t CPL_MULTI_PRE = 16'd2;
  localparam cpl_code_t CPL_BAD_WIDTH = 16'd3;
  localparam cpl_code_t CPL_MISALIGN  = 16'd4;

endpackage

// File: rtl/dma_desc_check.sv
module dma_desc_check
  import dma_seq_pkg::*;
#(
  parameter int NSEM  = 4,
  parameter int SEM_W = 32
) (
  input  logic [7:0]            cmd_i,
  input  logic [NSEM*SEM_W-1:0] sem_i,
  input  logic [7:0]            db_attr_i,
  input  logic [1:0]            db_addr_lo_i,
  output logic [NSEM-1:0]       pre_mask_o,
  output logic [NSEM-1:0]       post_mask_o,
  output cpl_code_t             code_o
);
  localparam int EN_BIT  = SEM_W - 1;
  localparam int PRE_BIT = SEM_W - 2;
  localparam int CNT_W   = $clog2(NSEM + 1);

  for (genvar g = 0; g < NSEM; g++) begin : g_mask
    assign pre_mask_o[g]  = sem_i[g*SEM_W+EN_BIT] &  sem_i[g*SEM_W+PRE_BIT];
    assign post_mask_o[g] = sem_i[g*SEM_W+EN_BIT] & ~sem_i[g*SEM_W+PRE_BIT];
  end

  logic [CNT_W-1:0] pre_cnt;
  always_comb begin
    pre_cnt = '0;
    for (int i = 0; i < NSEM; i++) pre_cnt = pre_cnt + CNT_W'(pre_mask_o[i]);
  end

  xfer_type_e xt;
  db_width_e  dw;
  logic       db_en;
  logic       misalign;

  assign xt       = xfer_type_e'(cmd_i[1:0]);
  assign dw       = db_width_e'(db_attr_i[1:0]);
  assign db_en    = db_attr_i[DB_EN_BIT];
  assign misalign = ((dw == DBW_32) && (db_addr_lo_i != 2'b00)) ||
                    ((dw == DBW_16) && db_addr_lo_i[0]);

  always_comb begin
    if (xt == XT_ILLEGAL)                code_o = CPL_BAD_TYPE;
    else if (pre_cnt > CNT_W'(1))        code_o = CPL_MULTI_PRE;
    else if (db_en && (dw == DBW_RSVD))  code_o = CPL_BAD_WIDTH;
    else if (db_en && misalign)          code_o = CPL_MISALIGN;
    else                                 code_o = CPL_OK;
  end

endmodule

// File: rtl/dma_sem_pick.sv
module dma_sem_pick #(
  parameter int N     = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_db_format.sv
module dma_db_format
  import dma_seq_pkg::*;
#(
  parameter int DB_W = 32
) (
  input  logic [1:0]      size_i,
  input  logic [DB_W-1:0] data_i,
  output logic [DB_W-1:0] data_o
);
  db_width_e dw;
  assign dw = db_width_e'(size_i);

  for (genvar g = 0; g < DB_W; g++) begin : g_lane
    if (g < 8) begin : g_b0
      assign data_o[g] = data_i[g];
    end else if (g < 16) begin : g_b1
      assign data_o[g] = data_i[g] & (dw != DBW_8);
    end else begin : g_hi
      assign data_o[g] = data_i[g] & (dw == DBW_32);
    end
  end
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int ID_W   = 16,
  parameter int SEQ_W  = 8,
  parameter int NSEM   = 4,
  parameter int SEM_W  = 32,
  parameter int DB_W   = 32,
  localparam int IDX_W = $clog2(NSEM)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  desc_valid_i,
  output logic                  desc_ready_o,
  input  logic [ID_W-1:0]       desc_req_id_i,
  input  logic [SEQ_W-1:0]      desc_seq_id_i,
  input  logic [7:0]            desc_cmd_i,
  input  logic [ADDR_W-1:0]     desc_src_i,
  input  logic [ADDR_W-1:0]     desc_dst_i,
  input  logic [LEN_W-1:0]      desc_len_i,
  input  logic [ADDR_W-1:0]     desc_db_addr_i,
  input  logic [7:0]            desc_db_attr_i,
  input  logic [DB_W-1:0]       desc_db_data_i,
  input  logic [NSEM*SEM_W-1:0] desc_sem_i,
  output logic                  xfer_valid_o,
  input  logic                  xfer_ready_i,
  output logic                  xfer_dir_o,
  output logic                  xfer_bulk_o,
  output logic [ADDR_W-1:0]     xfer_src_o,
  output logic [ADDR_W-1:0]     xfer_dst_o,
  output logic [LEN_W-1:0]      xfer_len_o,
  output logic                  sem_valid_o,
  input  logic                  sem_ready_i,
  output logic                  sem_pre_o,
  output logic [IDX_W-1:0]      sem_idx_o,
  output logic [SEM_W-1:0]      sem_cmd_o,
  output logic                  db_valid_o,
  input  logic                  db_ready_i,
  output logic [ADDR_W-1:0]     db_addr_o,
  output logic [1:0]            db_size_o,
  output logic [DB_W-1:0]       db_data_o,
  output logic                  rsp_valid_o,
  input  logic                  rsp_ready_i,
  output logic [ID_W-1:0]       rsp_req_id_o,
  output logic [SEQ_W-1:0]      rsp_seq_id_o,
  output logic [CODE_W-1:0]     rsp_code_o,
  output logic                  irq_o
);

  // ---------------- descriptor check on the incoming descriptor ----------
  logic [NSEM-1:0] chk_pre, chk_post;
  cpl_code_t       chk_code;

  dma_desc_check #(.NSEM(NSEM), .SEM_W(SEM_W)) u_check (
    .cmd_i        (desc_cmd_i),
    .sem_i        (desc_sem_i),
    .db_attr_i    (desc_db_attr_i),
    .db_addr_lo_i (desc_db_addr_i[1:0]),
    .pre_mask_o   (chk_pre),
    .post_mask_o  (chk_post),
    .code_o       (chk_code)
  );

  logic [IDX_W-1:0] pre_idx_in;
  dma_sem_pick #(.N(NSEM)) u_pick_pre (.mask_i(chk_pre), .idx_o(pre_idx_in));

  // ---------------- state ------------------------------------------------
  seq_state_e        state_q, state_d;
  logic [ID_W-1:0]   req_id_q;
  logic [SEQ_W-1:0]  seq_id_q;
  logic [1:0]        type_q;
  logic              bulk_q, want_rsp_q, force_irq_q, db_en_q;
  logic [ADDR_W-1:0] src_q, dst_q, db_addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        db_size_q;
  logic [DB_W-1:0]   db_data_q;
  logic [NSEM*SEM_W-1:0] sem_q;
  logic [NSEM-1:0]   post_q, post_d;
  logic [IDX_W-1:0]  pre_idx_q;
  cpl_code_t         err_q;
  logic              irq_q, irq_d;

  logic idle, accept;
  assign idle   = (state_q == ST_IDLE);
  assign accept = idle & desc_valid_i;

  logic unused_bits;
  assign unused_bits = ^{desc_cmd_i[6:5], desc_cmd_i[2], desc_db_attr_i[6:2]};

  // live view: incoming descriptor while idle, stored one otherwise
  logic [1:0]      live_type;
  logic            live_rsp, live_irq, live_db;
  logic [NSEM-1:0] live_post;
  assign live_type = idle ? desc_cmd_i[1:0]              : type_q;
  assign live_rsp  = idle ? desc_cmd_i[CMD_RSP_BIT]      : want_rsp_q;
  assign live_irq  = idle ? desc_cmd_i[CMD_IRQ_BIT]      : force_irq_q;
  assign live_db   = idle ? desc_db_attr_i[DB_EN_BIT]    : db_en_q;
  assign live_post = idle ? chk_post                     : post_q;

  logic [IDX_W-1:0] post_idx;
  logic [NSEM-1:0]  post_left;
  dma_sem_pick #(.N(NSEM)) u_pick_post (.mask_i(post_q), .idx_o(post_idx));
  assign post_left = post_q & ~(NSEM'(1) << post_idx);

  seq_state_e after_pre, after_xfer, after_post, after_db;
  assign after_db   = live_rsp ? ST_RSP : ST_IDLE;
  assign after_post = live_db ? ST_DB : after_db;
  assign after_xfer = (|live_post) ? ST_POST : after_post;
  assign after_pre  = (live_type[1] ^ live_type[0]) ? ST_XFER : after_xfer;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (desc_valid_i)
                 state_d = (chk_code != CPL_OK) ? ST_RSP :
                           (|chk_pre) ? ST_PRE : after_pre;
      ST_PRE:  if (sem_ready_i) state_d = after_pre;
      ST_XFER: if (xfer_ready_i) state_d = after_xfer;
      ST_POST: if (sem_ready_i && (post_left == '0)) state_d = after_post;
      ST_DB:   if (db_ready_i) state_d = after_db;
      ST_RSP:  if (rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    post_d = post_q;
    if (accept)                                   post_d = chk_post;
    else if ((state_q == ST_POST) && sem_ready_i) post_d = post_left;
  end

  assign irq_d = (state_d == ST_IDLE) && (!idle || desc_valid_i) && live_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      post_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      post_q  <= post_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_id_q <= '0; seq_id_q <= '0; type_q <= '0; bulk_q <= 1'b0;
      want_rsp_q <= 1'b0; force_irq_q <= 1'b0; db_en_q <= 1'b0;
      src_q <= '0; dst_q <= '0; len_q <= '0; db_addr_q <= '0;
      db_size_q <= '0; db_data_q <= '0; sem_q <= '0; pre_idx_q <= '0;
      err_q <= CPL_OK;
    end else if (accept) begin
      req_id_q    <= desc_req_id_i;
      seq_id_q    <= desc_seq_id_i;
      type_q      <= desc_cmd_i[1:0];
      bulk_q      <= desc_cmd_i[CMD_BULK_BIT];
      want_rsp_q  <= desc_cmd_i[CMD_RSP_BIT];
      force_irq_q <= desc_cmd_i[CMD_IRQ_BIT];
      db_en_q     <= desc_db_attr_i[DB_EN_BIT];
      src_q       <= desc_src_i;
      dst_q       <= desc_dst_i;
      len_q       <= desc_len_i;
      db_addr_q   <= desc_db_addr_i;
      db_size_q   <= desc_db_attr_i[1:0];
      db_data_q   <= desc_db_data_i;
      sem_q       <= desc_sem_i;
      pre_idx_q   <= pre_idx_in;
      err_q       <= chk_code;
    end
  end

  // ---------------- outputs ---------------------------------------------
  logic [SEM_W-1:0] sem_arr [NSEM];
  for (genvar g = 0; g < NSEM; g++) begin : g_sem
    assign sem_arr[g] = sem_q[g*SEM_W +: SEM_W];
  end

  assign desc_ready_o = idle;
  assign xfer_valid_o = (state_q == ST_XFER);
  assign xfer_dir_o   = (xfer_type_e'(type_q) == XT_TO_DEV);
  assign xfer_bulk_o  = bulk_q;
  assign xfer_src_o   = src_q;
  assign xfer_dst_o   = dst_q;
  assign xfer_len_o   = len_q;
  assign sem_valid_o  = (state_q == ST_PRE) || (state_q == ST_POST);
  assign sem_pre_o    = (state_q == ST_PRE);
  assign sem_idx_o    = sem_pre_o ? pre_idx_q : post_idx;
  assign sem_cmd_o    = sem_arr[sem_idx_o];
  assign db_valid_o   = (state_q == ST_DB);
  assign db_addr_o    = db_addr_q;
  assign db_size_o    = db_size_q;
  assign rsp_valid_o  = (state_q == ST_RSP);
  assign rsp_req_id_o = req_id_q;
  assign rsp_seq_id_o = seq_id_q;
  assign rsp_code_o   = err_q;
  assign irq_o        = irq_q;

  dma_db_format #(.DB_W(DB_W)) u_db_fmt (
    .size_i (db_size_q),
    .data_i (db_data_q),
    .data_o (db_data_o)
  );

  // ---------------- assertions ------------------------------------------
  a_r2_one_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_valid_o, sem_valid_o, db_valid_o, rsp_valid_o}));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready_o |-> !(xfer_valid_o || sem_valid_o || db_valid_o || rsp_valid_o));

  a_r12_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(xfer_src_o) && $stable(xfer_dst_o) && $stable(xfer_len_o)));

  a_r12_sem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_valid_o && !sem_ready_i) |=> (sem_valid_o && $stable(sem_cmd_o) && $stable(sem_idx_o)));

  a_r4_post_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_valid_o && !sem_pre_o && sem_ready_i) |=>
      (!(sem_valid_o && !sem_pre_o) || (sem_idx_o > $past(sem_idx_o))));

  a_r7_db_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid_o |-> ((db_size_o != 2'd3) &&
                    !((db_size_o == 2'd0) && (db_addr_o[1:0] != 2'b00)) &&
                    !((db_size_o == 2'd1) && db_addr_o[0])));

  a_r6_db_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid_o && (db_size_o == 2'd2)) |-> (db_data_o[DB_W-1:8] == '0));

  a_r9_err_direct: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid_o) && (rsp_code_o != CPL_OK)) |-> $past(desc_ready_o && desc_valid_i));

endmodule

// File: tb/dma_req_seq_bench.sv
module dma_req_seq_bench;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic        desc_valid, desc_ready;
  logic [15:0] d_req;
  logic [7:0]  d_seq, d_cmd, d_attr;
  logic [63:0] d_src, d_dst, d_dba;
  logic [31:0] d_len, d_dbd;
  logic [31:0] d_sem [4];
  logic [15:0] i_req;
  logic [7:0]  i_seq, i_cmd, i_attr;
  logic [63:0] i_src, i_dst, i_dba;
  logic [31:0] i_len, i_dbd;
  logic [127:0] i_sem;

  logic        xfer_valid, xfer_ready, xfer_dir, xfer_bulk;
  logic [63:0] xfer_src, xfer_dst;
  logic [31:0] xfer_len;
  logic        sem_valid, sem_ready, sem_pre;
  logic [1:0]  sem_idx;
  logic [31:0] sem_cmd;
  logic        db_valid, db_ready;
  logic [63:0] db_addr;
  logic [1:0]  db_size;
  logic [31:0] db_data;
  logic        rsp_valid, rsp_ready;
  logic [15:0] rsp_req, rsp_code;
  logic [7:0]  rsp_seq;
  logic        irq;

  dma_req_seq u_dma_req_seq (
    .clk(clk), .rst_n(rst_n),
    .desc_valid_i(desc_valid), .desc_ready_o(desc_ready),
    .desc_req_id_i(i_req), .desc_seq_id_i(i_seq), .desc_cmd_i(i_cmd),
    .desc_src_i(i_src), .desc_dst_i(i_dst), .desc_len_i(i_len),
    .desc_db_addr_i(i_dba), .desc_db_attr_i(i_attr), .desc_db_data_i(i_dbd),
    .desc_sem_i(i_sem),
    .xfer_valid_o(xfer_valid), .xfer_ready_i(xfer_ready), .xfer_dir_o(xfer_dir),
    .xfer_bulk_o(xfer_bulk), .xfer_src_o(xfer_src), .xfer_dst_o(xfer_dst), .xfer_len_o(xfer_len),
    .sem_valid_o(sem_valid), .sem_ready_i(sem_ready), .sem_pre_o(sem_pre),
    .sem_idx_o(sem_idx), .sem_cmd_o(sem_cmd),
    .db_valid_o(db_valid), .db_ready_i(db_ready), .db_addr_o(db_addr),
    .db_size_o(db_size), .db_data_o(db_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_req_id_o(rsp_req),
    .rsp_seq_id_o(rsp_seq), .rsp_code_o(rsp_code), .irq_o(irq)
  );

  int nchk = 0;
  int nerr = 0;
  int          act_k [$];
  logic [63:0] act_v [$];
  int          exp_k [$];
  logic [63:0] exp_v [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic void snap(output int k, output logic [63:0] v);
    k = 0; v = '0;
    if (xfer_valid) begin
      k = 2; v = xfer_src ^ xfer_dst ^ {30'd0, xfer_bulk, xfer_dir, xfer_len};
    end else if (sem_valid) begin
      k = sem_pre ? 1 : 3; v = {30'd0, sem_idx, sem_cmd};
    end else if (db_valid) begin
      k = 4; v = db_addr ^ {30'd0, db_size, db_data};
    end else if (rsp_valid) begin
      k = 5; v = {24'd0, rsp_seq, rsp_req, rsp_code};
    end
  endfunction

  // responder for all four request ports
  initial begin
    int k, k0, dly;
    logic [63:0] v, v0;
    bit pend;
    xfer_ready = 0; sem_ready = 0; db_ready = 0; rsp_ready = 0;
    pend = 0; dly = 0; k0 = 0; v0 = '0;
    forever begin
      @(negedge clk);
      if (xfer_ready | sem_ready | db_ready | rsp_ready) begin
        xfer_ready = 0; sem_ready = 0; db_ready = 0; rsp_ready = 0; pend = 0;
      end else if (rst_n && (xfer_valid | sem_valid | db_valid | rsp_valid)) begin
        snap(k, v);
        if (!pend) begin pend = 1; k0 = k; v0 = v; dly = int'($urandom % 4); end
        if (dly == 0) begin
          chk((k == k0) && (v == v0), "R12 held request", v, v0);
          act_k.push_back(k); act_v.push_back(v);
          case (k)
            2:       xfer_ready = 1;
            1, 3:    sem_ready  = 1;
            4:       db_ready   = 1;
            default: rsp_ready  = 1;
          endcase
        end else dly--;
      end
    end
  end

  function automatic void build_exp(output bit eirq, output logic [15:0] eerr);
    int npre, pidx;
    logic [1:0] t, w;
    bit dben, mis;
    logic [31:0] m;
    npre = 0; pidx = 0;
    t = d_cmd[1:0]; w = d_attr[1:0]; dben = d_attr[7];
    for (int i = 0; i < 4; i++)
      if (d_sem[i][31] && d_sem[i][30]) begin npre++; pidx = i; end
    mis = ((w == 2'd0) && (d_dba[1:0] != 2'b00)) || ((w == 2'd1) && d_dba[0]);
    if (t == 2'd3)             eerr = 16'd1;
    else if (npre > 1)         eerr = 16'd2;
    else if (dben && w == 3)   eerr = 16'd3;
    else if (dben && mis)      eerr = 16'd4;
    else                       eerr = 16'd0;
    eirq = d_cmd[7];
    if (eerr != 0) begin
      exp_k.push_back(5); exp_v.push_back({24'd0, d_seq, d_req, eerr});
      return;
    end
    if (npre == 1) begin exp_k.push_back(1); exp_v.push_back({30'd0, 2'(pidx), d_sem[pidx]}); end
    if (t != 2'd0) begin
      exp_k.push_back(2);
      exp_v.push_back(d_src ^ d_dst ^ {30'd0, d_cmd[3], (t == 2'd1), d_len});
    end
    for (int i = 0; i < 4; i++)
      if (d_sem[i][31] && !d_sem[i][30]) begin
        exp_k.push_back(3); exp_v.push_back({30'd0, 2'(i), d_sem[i]});
      end
    if (dben) begin
      m = (w == 2'd0) ? d_dbd : (w == 2'd1) ? {16'd0, d_dbd[15:0]} : {24'd0, d_dbd[7:0]};
      exp_k.push_back(4); exp_v.push_back(d_dba ^ {30'd0, w, m});
    end
    if (d_cmd[4]) begin exp_k.push_back(5); exp_v.push_back({24'd0, d_seq, d_req, 16'd0}); end
  endfunction

  function automatic string tag_of(int k, logic [15:0] e);
    if (e != 0) return "R9 error completion";
    case (k)
      1: return "R5 pre-sync";
      2: return "R3 transfer";
      3: return "R4 post-sync";
      4: return "R6 doorbell";
      default: return "R8 R11 response";
    endcase
  endfunction

  task automatic run_req();
    bit eirq;
    logic [15:0] eerr;
    act_k.delete(); act_v.delete(); exp_k.delete(); exp_v.delete();
    build_exp(eirq, eerr);
    i_req = d_req; i_seq = d_seq; i_cmd = d_cmd; i_src = d_src; i_dst = d_dst;
    i_len = d_len; i_dba = d_dba; i_attr = d_attr; i_dbd = d_dbd;
    i_sem = {d_sem[3], d_sem[2], d_sem[1], d_sem[0]};
    desc_valid = 1;
    @(negedge clk);
    desc_valid = 0;
    while (!desc_ready) @(negedge clk);
    chk(irq == eirq, "R10 interrupt pulse", 64'(irq), 64'(eirq));
    chk(act_k.size() == exp_k.size(), (eerr != 0) ? "R9 stage count" : "R2 stage count",
        64'(act_k.size()), 64'(exp_k.size()));
    if (act_k.size() == exp_k.size())
      for (int i = 0; i < exp_k.size(); i++) begin
        chk(act_k[i] == exp_k[i], "R2 stage order", 64'(act_k[i]), 64'(exp_k[i]));
        chk(act_v[i] == exp_v[i], tag_of(exp_k[i], eerr), act_v[i], exp_v[i]);
      end
    @(negedge clk);
    chk(irq == 1'b0, "R10 single pulse", 64'(irq), 64'd0);
  endtask

  task automatic clear_desc();
    d_req = 16'h0; d_seq = 8'h0; d_cmd = 8'h0; d_attr = 8'h0;
    d_src = '0; d_dst = '0; d_dba = '0; d_len = '0; d_dbd = '0;
    for (int i = 0; i < 4; i++) d_sem[i] = '0;
  endtask

  task automatic rand_desc();
    logic [31:0] r;
    d_req = 16'($urandom); d_seq = 8'($urandom);
    d_cmd = 8'($urandom);
    if ($urandom % 6 != 0) d_cmd[1:0] = 2'($urandom % 3);
    d_src = {$urandom, $urandom}; d_dst = {$urandom, $urandom}; d_len = $urandom;
    d_dbd = $urandom; d_dba = {$urandom, $urandom};
    d_attr = 8'($urandom);
    if ($urandom % 8 != 0) d_attr[1:0] = 2'($urandom % 3);
    if ($urandom % 4 != 0) d_dba[1:0] = 2'b00;
    for (int i = 0; i < 4; i++) begin
      r = $urandom;
      r[31] = ($urandom % 2 == 0);
      r[30] = ($urandom % 7 == 0);
      d_sem[i] = r;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R2 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; desc_valid = 0;
    clear_desc();
    i_req = '0; i_seq = '0; i_cmd = '0; i_src = '0; i_dst = '0; i_len = '0;
    i_dba = '0; i_attr = '0; i_dbd = '0; i_sem = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(desc_ready == 1'b1, "R1 reset ready", 64'(desc_ready), 64'd1);
    chk({xfer_valid, sem_valid, db_valid, rsp_valid} == 4'b0, "R1 reset valids",
        64'({xfer_valid, sem_valid, db_valid, rsp_valid}), 64'd0);
    chk(irq == 1'b0, "R1 reset irq", 64'(irq), 64'd0);

    // all stages: pre on entry 2, posts on 0,1,3, 16-bit doorbell, response, irq
    clear_desc();
    d_req = 16'hBEEF; d_seq = 8'h5A; d_cmd = 8'b1001_1001;
    d_src = 64'h1000; d_dst = 64'h2000; d_len = 32'hFFFF_FFFF;
    d_sem[0] = 32'h8000_0011; d_sem[1] = 32'h8000_0022;
    d_sem[2] = 32'hC000_0033; d_sem[3] = 32'h8000_0044;
    d_attr = 8'h81; d_dba = 64'h4002; d_dbd = 32'hDEAD_BEEF;
    run_req();
    // nothing enabled, forced interrupt only
    clear_desc(); d_cmd = 8'h80; run_req();
    // nothing enabled, no interrupt
    clear_desc(); run_req();
    // R9 illegal type
    clear_desc(); d_cmd = 8'h03; d_req = 16'h0101; run_req();
    // R9 two pre-sync entries
    clear_desc(); d_cmd = 8'h11; d_sem[0] = 32'hC000_0001; d_sem[3] = 32'hC000_0002; run_req();
    // R9 reserved doorbell width
    clear_desc(); d_attr = 8'h83; run_req();
    // R7 misaligned 32-bit doorbell
    clear_desc(); d_attr = 8'h80; d_dba = 64'h12; d_cmd = 8'h80; run_req();
    // R7 misaligned 16-bit doorbell
    clear_desc(); d_attr = 8'h81; d_dba = 64'h11; run_req();
    // R7 8-bit doorbell at an odd address is legal
    clear_desc(); d_attr = 8'h82; d_dba = 64'h13; d_dbd = 32'hA5A5_A5A5; d_cmd = 8'h10; run_req();
    // R9 reserved width with doorbell disabled is legal
    clear_desc(); d_attr = 8'h03; d_dba = 64'h1; d_cmd = 8'h12; run_req();
    // R9 priority: illegal type beats misalignment
    clear_desc(); d_cmd = 8'h03; d_attr = 8'h80; d_dba = 64'h1; run_req();
    // R3 device-to-host linked-list transfer only, R11 seq id
    clear_desc(); d_cmd = 8'h12; d_seq = 8'hC3; d_len = 32'h40; run_req();

    for (int n = 0; n < 300; n++) begin
      rand_desc();
      run_req();
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule